// File: doc/BRIEF.md
# Fuse-Programmed Sum-of-Products Array

This block is a programmable logic array held in on-chip fuse storage. Ten dedicated inputs and six pad feedback signals make up sixteen array signals. Each signal enters the array in both polarities, which gives thirty-two columns. Sixty-four product terms each AND together the columns whose fuse is intact. The terms are split among eight output slices of eight terms each. In every slice, the first term drives the pad's output enable. The other seven terms are ORed, and the result drives the pad inverted.

Slices 1 to 6 are bidirectional. The level on each of their pads returns to the array as an input signal. When the slice drives its pad, that level is the driven value; when the slice has released the pad, it is the externally supplied value. Slices 0 and 7 are output-only. Each pad is modelled as a separate value output and enable output.

The fuse map is written one bit at a time through a simple write port. The port accepts writes only while the configuration mode input is held high. While that input is high, every output enable is forced off.

Top module: `sop_array`

## Requirements
- R1: A write with `cfg_mode`=1 and `cfg_we`=1 stores `cfg_data` into fuse `cfg_addr` at the clock edge. The address is row*32 + column, and the new value affects the outputs from the next cycle on.
- R2: Writes presented while `cfg_mode`=0 leave the fuse map unchanged.
- R3: While `cfg_mode`=1, every bit of `out_oe` is 0.
- R4: Synchronous reset makes every fuse intact (1). After reset, every product term is 0, so `out_oe` is all 0 and `out_val` is all 1.
- R5: Array signal k drives column 2k in true form and column 2k+1 in complement form. Signals 0 to 9 are `ded_in[0..9]`. Signals 10 to 15 are the pad levels of slices 1 to 6.
- R6: A product term is the AND of the columns whose fuse is 1. A row whose fuses are all 0 evaluates to 1. A row with both columns of any one signal intact evaluates to 0.
- R7: Slice s owns rows 8s to 8s+7. `out_val[s]` is the inverse of the OR of rows 8s+1 to 8s+7.
- R8: Outside configuration mode, `out_oe[s]` equals product term 8s. This holds for output-only slices as well.
- R9: For bidirectional slice j+1, the fed-back level is `out_val[j+1]` when `out_oe[j+1]`=1 and `pad_in[j]` when `out_oe[j+1]`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for fuse storage |
| rst | input | 1 | Synchronous active-high reset; all fuses become intact |
| cfg_mode | input | 1 | Configuration mode: enables writes, disables all outputs |
| cfg_we | input | 1 | Fuse write strobe |
| cfg_addr | input | 11 | Fuse index, row*32 + column |
| cfg_data | input | 1 | Fuse value: 1 intact, 0 blown |
| ded_in | input | 10 | Dedicated array inputs |
| pad_in | input | 6 | External level on bidirectional pads of slices 1 to 6 |
| out_val | output | 8 | Value each slice drives onto its pad |
| out_oe | output | 8 | Output enable of each slice |

## Verification
Four small maps are programmed, and each is swept over its input combinations. A two-literal term against an inverted output shows which column holds the true form and which the complement, and confirms the inversion. An enable term fed from one dedicated input, chained into a second slice through feedback, shows whether feedback follows the driven value or `pad_in`: the two sources are set to disagree. A fully blown row and a row with both polarities of one signal intact separate the constant-1 and constant-0 corner cases. Write attempts outside configuration mode, a check of the enables while in configuration mode, and a reset in the middle of the run show that the map only changes when it should.

// File: rtl/sop_pkg.sv
package sop_pkg;

    // Default geometry of the array
    localparam int DED_DEFAULT   = 10;
    localparam int BIDIR_DEFAULT = 6;
    localparam int TERMS_DEFAULT = 8;

    // One output slice's result, as seen at its pad
    typedef struct packed {
        logic val;
        logic oe;
    } slice_out_t;

    typedef enum logic {
        SLICE_OUT_ONLY = 1'b0,
        SLICE_BIDIR    = 1'b1
    } slice_kind_e;

    // The first and last slices are output-only; all slices between them feed back
    function automatic slice_kind_e slice_kind(input int s, input int n_slice);
        return (s == 0 || s == n_slice - 1) ? SLICE_OUT_ONLY : SLICE_BIDIR;
    endfunction

    function automatic int true_col(input int k);
        return 2 * k;
    endfunction

    function automatic int comp_col(input int k);
        return 2 * k + 1;
    endfunction

endpackage

// File: rtl/sop_fuse_store.sv
module sop_fuse_store #(
    parameter int ROWS = 64,
    parameter int COLS = 32,
    localparam int FUSES = ROWS * COLS,
    localparam int AW    = $clog2(FUSES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_mode,
    input  logic             cfg_we,
    input  logic [AW-1:0]    cfg_addr,
    input  logic             cfg_data,
    output logic [FUSES-1:0] fuse_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            fuse_q <= '1;
        end else if (cfg_mode && cfg_we) begin
            fuse_q[cfg_addr] <= cfg_data;
        end
    end

    // R1: an accepted write lands at the addressed fuse
    p_write_lands_r1: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode && cfg_we) |=> (fuse_q[$past(cfg_addr)] == $past(cfg_data)));

    // R2: the map is frozen outside configuration mode
    p_locked_map_r2: assert property (@(posedge clk) disable iff (rst)
        !cfg_mode |=> $stable(fuse_q));

endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane #(
    parameter int ROWS = 64,
    parameter int COLS = 32,
    localparam int FUSES = ROWS * COLS
) (
    input  logic [FUSES-1:0] fuse_q,
    input  logic [COLS-1:0]  cols,
    output logic [ROWS-1:0]  terms
);

    // An intact fuse lets its column pull the term low; a blown fuse masks it
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign terms[r] = &(cols | ~fuse_q[r*COLS +: COLS]);
    end

endmodule

// File: rtl/sop_out_slice.sv
module sop_out_slice
    import sop_pkg::*;
#(
    parameter int TERMS = 8
) (
    input  logic [TERMS-1:0] terms,
    input  logic             cfg_mode,
    output slice_out_t       res
);

    logic sum;

    always_comb begin
        sum     = |terms[TERMS-1:1];
        res.val = ~sum;
        res.oe  = terms[0] & ~cfg_mode;
    end

endmodule

// File: rtl/sop_array.sv
module sop_array
    import sop_pkg::*;
#(
    parameter int N_DED   = DED_DEFAULT,
    parameter int N_BIDIR = BIDIR_DEFAULT,
    parameter int TERMS   = TERMS_DEFAULT,
    localparam int N_SLICE = N_BIDIR + 2,
    localparam int N_SIG   = N_DED + N_BIDIR,
    localparam int COLS    = 2 * N_SIG,
    localparam int ROWS    = N_SLICE * TERMS,
    localparam int FUSES   = ROWS * COLS,
    localparam int AW      = $clog2(FUSES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_mode,
    input  logic               cfg_we,
    input  logic [AW-1:0]      cfg_addr,
    input  logic               cfg_data,
    input  logic [N_DED-1:0]   ded_in,
    input  logic [N_BIDIR-1:0] pad_in,
    output logic [N_SLICE-1:0] out_val,
    output logic [N_SLICE-1:0] out_oe
);

    logic [FUSES-1:0]   fuse_q;
    logic [N_SIG-1:0]   sig;
    logic [COLS-1:0]    cols;
    logic [ROWS-1:0]    terms;
    logic [N_BIDIR-1:0] fb;
    slice_out_t         res [N_SLICE];

    sop_fuse_store #(.ROWS(ROWS), .COLS(COLS)) u_store (
        .clk      (clk),
        .rst      (rst),
        .cfg_mode (cfg_mode),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_data (cfg_data),
        .fuse_q   (fuse_q)
    );

    // Array signals: dedicated inputs first, then pad feedback
    for (genvar k = 0; k < N_DED; k++) begin : g_ded
        assign sig[k] = ded_in[k];
    end
    for (genvar j = 0; j < N_BIDIR; j++) begin : g_fbsig
        assign sig[N_DED + j] = fb[j];
    end
    for (genvar k = 0; k < N_SIG; k++) begin : g_col
        assign cols[true_col(k)] = sig[k];
        assign cols[comp_col(k)] = ~sig[k];
    end

    sop_and_plane #(.ROWS(ROWS), .COLS(COLS)) u_and (
        .fuse_q (fuse_q),
        .cols   (cols),
        .terms  (terms)
    );

    for (genvar s = 0; s < N_SLICE; s++) begin : g_slice
        sop_out_slice #(.TERMS(TERMS)) u_slice (
            .terms    (terms[s*TERMS +: TERMS]),
            .cfg_mode (cfg_mode),
            .res      (res[s])
        );
        assign out_val[s] = res[s].val;
        assign out_oe[s]  = res[s].oe;

        // R7: any true sum term pulls the pad value low
        p_inverted_out_r7: assert property (@(posedge clk) disable iff (rst)
            (|terms[s*TERMS+1 +: TERMS-1]) |-> !out_val[s]);

        // R8: outside configuration the enable follows the slice's first row
        p_enable_row_r8: assert property (@(posedge clk) disable iff (rst)
            !cfg_mode |-> (out_oe[s] == terms[s*TERMS]));

        // Pad level seen by the array: driven value or the external one
        if (slice_kind(s, N_SLICE) == SLICE_BIDIR) begin : g_fb
            assign fb[s-1] = out_oe[s] ? out_val[s] : pad_in[s-1];

            p_fb_driven_r9: assert property (@(posedge clk) disable iff (rst)
                out_oe[s] |-> (sig[N_DED + s - 1] == out_val[s]));
            p_fb_released_r9: assert property (@(posedge clk) disable iff (rst)
                !out_oe[s] |-> (sig[N_DED + s - 1] == pad_in[s-1]));
        end
    end

    // R6 corner rows: empty row is 1, contradictory row is 0
    for (genvar r = 0; r < ROWS; r++) begin : g_rowchk
        logic [N_SIG-1:0] both_kept;
        for (genvar k = 0; k < N_SIG; k++) begin : g_pair
            assign both_kept[k] = fuse_q[r*COLS + true_col(k)] & fuse_q[r*COLS + comp_col(k)];
        end
        p_blank_row_r6: assert property (@(posedge clk) disable iff (rst)
            (fuse_q[r*COLS +: COLS] == '0) |-> terms[r]);
        p_conflict_row_r6: assert property (@(posedge clk) disable iff (rst)
            (|both_kept) |-> !terms[r]);
    end

    // R3: configuration mode silences every pad
    p_cfg_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        cfg_mode |-> (out_oe == '0));

endmodule

// File: tb/sop_array_test.sv
module sop_array_test;

    localparam int ND = 10;
    localparam int NB = 6;
    localparam int NS = 8;
    localparam int NR = 64;
    localparam int NC = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_mode;
    logic          cfg_we;
    logic [10:0]   cfg_addr;
    logic          cfg_data;
    logic [ND-1:0] ded_in;
    logic [NB-1:0] pad_in;
    logic [NS-1:0] out_val;
    logic [NS-1:0] out_oe;

    always #10 clk = ~clk;

    sop_array uut (
        .clk      (clk),
        .rst      (rst),
        .cfg_mode (cfg_mode),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_data (cfg_data),
        .ded_in   (ded_in),
        .pad_in   (pad_in),
        .out_val  (out_val),
        .out_oe   (out_oe)
    );

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    int       checks = 0;
    int       errors = 0;
    bit       done   = 0;
    logic     fz [NR*NC];

    // Requirement model: {oe, val} for every slice
    function automatic logic [15:0] model(input logic [ND-1:0] d, input logic [NB-1:0] p, input logic cm);
        logic [NB-1:0] fb;
        logic [15:0]   sg;
        logic [NC-1:0] cl;
        logic [NR-1:0] t;
        logic [NS-1:0] v, o;
        fb = p;
        v  = '1;
        o  = '0;
        for (int it = 0; it < 8; it++) begin
            sg = {fb, d};
            for (int k = 0; k < 16; k++) begin
                cl[2*k]   = sg[k];
                cl[2*k+1] = ~sg[k];
            end
            for (int r = 0; r < NR; r++) begin
                t[r] = 1'b1;
                for (int c = 0; c < NC; c++)
                    if (fz[r*NC+c] && !cl[c]) t[r] = 1'b0;
            end
            for (int s = 0; s < NS; s++) begin
                o[s] = t[s*8] & ~cm;
                v[s] = ~(|t[s*8+1 +: 7]);
            end
            for (int j = 0; j < NB; j++)
                fb[j] = o[j+1] ? v[j+1] : p[j];
        end
        return {o, v};
    endfunction

    // Monitor: compares away from the active edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            sb_item_t it;
            it = sb_q.pop_front();
            checks++;
            if ({out_oe, out_val} !== it.exp) begin
                errors++;
                $display("FAIL %s: actual oe=%b val=%b expected oe=%b val=%b",
                         it.tag, out_oe, out_val, it.exp[15:8], it.exp[7:0]);
            end
        end
    end

    task automatic wr(input int a, input logic b);
        cfg_we   = 1'b1;
        cfg_addr = 11'(a);
        cfg_data = b;
        if (cfg_mode) fz[a] = b;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic set_row(input int r, input logic [31:0] keep);
        for (int c = 0; c < NC; c++) wr(r*NC + c, keep[c]);
    endtask

    task automatic chk(input logic [ND-1:0] d, input logic [NB-1:0] p, input string tag);
        sb_item_t it;
        ded_in = d;
        pad_in = p;
        it.exp = model(d, p, cfg_mode);
        it.tag = tag;
        sb_q.push_back(it);
        @(posedge clk); #1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk); #1;
        rst = 1'b0;
        for (int i = 0; i < NR*NC; i++) fz[i] = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        cfg_mode = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_data = 1'b0;
        ded_in = '0; pad_in = '0; rst = 1'b1;
        @(posedge clk); #1;
        do_reset();

        // R4: all intact after reset -> enables off, values high
        chk(10'h000, 6'h00, "R4 reset state A");
        chk(10'h3FF, 6'h3F, "R4 reset state B");

        // R2: writes outside configuration are dropped (slice 7 enable row)
        set_row(56, 32'h0000_0000);
        chk(10'h000, 6'h00, "R2 locked write has no effect");

        // Program maps in configuration mode
        cfg_mode = 1'b1;
        set_row(0, 32'h0000_0000);          // slice 0 always enabled
        set_row(1, 32'h0000_0009);          // ded0 & ~ded1 (cols 0,3)
        set_row(8, 32'h0000_0010);          // slice 1 enable = ded2 (col 4)
        set_row(9, 32'h0000_0040);          // slice 1 term = ded3 (col 6)
        set_row(16, 32'h0000_0000);         // slice 2 always enabled
        set_row(17, 32'h0010_0000);         // slice 2 term = fb of slice 1 (col 20)
        set_row(24, 32'h0000_0000);
        set_row(25, 32'h0000_0000);         // blank row -> 1
        set_row(32, 32'h0000_0000);
        set_row(33, 32'h0000_0300);         // ded4 & ~ded4 -> 0
        set_row(56, 32'h0004_0000);         // slice 7 enable = ded9 (col 18)
        set_row(57, 32'h0008_0000);         // slice 7 term = ~ded9 (col 19)

        // R3: nothing enabled while configuring
        chk(10'h3FF, 6'h3F, "R3 enables off in config mode");
        cfg_mode = 1'b0;

        // R1 R5 R7 R8: slice 0 over all ded0/ded1 combinations
        for (int i = 0; i < 4; i++)
            chk(10'(i), 6'h00, "R1 R5 R7 R8 slice0 product ded0 & ~ded1");

        // R9: slice 1 released -> slice 2 sees pad_in[0]
        chk(10'h008, 6'h01, "R9 released pad feeds back pad_in high");
        chk(10'h008, 6'h00, "R9 released pad feeds back pad_in low");
        // R9: slice 1 driving -> feedback is its value, pad_in disagrees
        chk(10'h004, 6'h00, "R9 driven pad overrides pad_in (val 1)");
        chk(10'h00C, 6'h01, "R9 driven pad overrides pad_in (val 0)");

        // R6: blank row is 1, contradictory row is 0
        chk(10'h010, 6'h00, "R6 blank and conflict rows, ded4=1");
        chk(10'h000, 6'h3F, "R6 blank and conflict rows, ded4=0");

        // R8: output-only slice 7 enable from ded9
        chk(10'h200, 6'h00, "R8 slice7 enabled ded9=1");
        chk(10'h000, 6'h00, "R8 slice7 released ded9=0");

        // R4: reset in mid-run restores the blank map
        do_reset();
        chk(10'h3FF, 6'h00, "R4 reset clears programmed map");

        done = 1;
        @(negedge clk); #1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule